// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host read and write the 16-bit registers of Ethernet PHYs over the two-wire management bus. The host presents a PHY address, a register address, write data and a clock divider select. It then issues a one-cycle command strobe carrying an op code. The block produces a complete management frame on MDC/MDIO, collects the returned data for a read, and raises a sticky completion flag when the frame is done.

MDC is derived from the bus clock. Each half period of MDC lasts `divSel` bus cycles, so the MDC frequency is the bus frequency divided by 2 × `divSel`. With a 25 MHz bus clock, `divSel` = 5 gives the 2.5 MHz ceiling.

The MDIO pin is split into a driven value, an output enable and a sampled input, for an external tristate pad. Each frame is 64 bits, sent MSB first, in this order:
- 32 preamble ones
- start code 01
- the 2-bit op
- 5-bit PHY address
- 5-bit register address
- 2-bit turnaround
- 16 data bits

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy`, `doneFlag`, `mdc`, `mdioOe` are 0 and `rdData` is 0.
- R2: A `cmdWr` pulse with `cmdOp` 01 (write) or 10 (read), while `busy` is 0 and `divSel` is nonzero, sets `busy` at the next clock edge. `busy` then stays high for exactly 128 × `divSel` bus cycles.
- R3: During a frame, each MDC half period lasts `divSel` bus cycles and MDC shows exactly 64 rising edges. MDC is low whenever `busy` is 0.
- R4: At the 64 MDC rising edges, `mdioOut` carries, MSB first, 32 ones, then 01, then the op code, then `phyAddr`[4:0], then `regAddr`[4:0]. MDIO changes one bus cycle after each MDC rising edge.
- R5: In a write frame, bits 46..47 are 1 then 0, bits 48..63 are `wrData` MSB first, and `mdioOe` is 1 for all 64 bits.
- R6: In a read frame, `mdioOe` is 1 for bits 0..45 and 0 from bit 46 on. `mdioIn` is sampled at the MDC rising edges of bits 48..63, MSB first. The result is loaded into `rdData` at the edge where `busy` clears. A write frame leaves `rdData` unchanged.
- R7: `doneFlag` is set at the edge where `busy` clears and stays set until `doneClr` is 1. If both happen at the same edge, the set wins.
- R8: A command with op 00 or 11, or with `divSel` 0, is ignored: `busy` stays 0 and MDC stays low. A command issued while `busy` is 1 is also ignored, including any address, data or op change it carries.
- R9: `divSel` is captured when a command is accepted. Changing it during a frame does not alter the frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdWr | input | 1 | Command strobe, one cycle |
| cmdOp | input | 2 | Op code: 01 write, 10 read |
| phyAddr | input | 5 | Target PHY address |
| regAddr | input | 5 | Target PHY register |
| wrData | input | 16 | Data for a write frame |
| divSel | input | DIVW | MDC half-period in bus cycles |
| doneClr | input | 1 | Write-1 clear of doneFlag |
| rdData | output | 16 | Result of the last read frame |
| busy | output | 1 | Frame in progress |
| doneFlag | output | 1 | Sticky completion flag |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Value driven onto MDIO |
| mdioOe | output | 1 | MDIO drive enable |
| mdioIn | input | 1 | Value sampled from MDIO |

## Verification
The bench counts the falling bus-clock edges that see `busy` high after the accepting edge. That count must equal 128 × `divSel`; `doneFlag` and `rdData` are checked at the first falling edge after `busy` drops. A model PHY in the bench records `mdioOut` and `mdioOe` at each MDC rising edge. This is safe because the block moves MDIO one bus cycle after the rise. The model drives the next read bit right after each rise, so that bit is settled a full half period before the block samples it. Ignored commands are checked by holding ten cycles and confirming that no MDC edge appeared and `busy` never rose.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;
  localparam int IDXW      = $clog2(FRAME_LEN + 1);

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef struct packed {
    logic            load;    // command accepted, capture frame
    logic            shift;   // advance MDIO one bit
    logic            sample;  // MDC rising edge, sample mdioIn
    logic            finish;  // frame complete
    logic [IDXW-1:0] bitIdx;  // rising edges seen so far
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdWr,
  input  logic [1:0]      cmdOp,
  input  logic [DIVW-1:0] divSel,
  output logic            busy,
  output logic            mdc,
  output mdioStrobe_t     strb
);
  logic [DIVW-1:0] divLat;
  logic [DIVW-1:0] divCnt;
  logic [IDXW-1:0] riseCnt;
  logic accept, halfEnd, riseNow, fallNow, lastFall;

  assign accept   = cmdWr && !busy && ((cmdOp == OP_WR) || (cmdOp == OP_RD)) && (divSel != '0);
  assign halfEnd  = busy && (divCnt == divLat - 1'b1);
  assign riseNow  = halfEnd && !mdc;
  assign fallNow  = halfEnd && mdc;
  assign lastFall = fallNow && (riseCnt == IDXW'(FRAME_LEN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      mdc     <= 1'b0;
      divLat  <= '0;
      divCnt  <= '0;
      riseCnt <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      mdc     <= 1'b0;
      divLat  <= divSel;
      divCnt  <= '0;
      riseCnt <= '0;
    end else if (busy) begin
      if (halfEnd) begin
        divCnt <= '0;
        mdc    <= ~mdc;
        if (riseNow)  riseCnt <= riseCnt + 1'b1;
        if (lastFall) busy    <= 1'b0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.load   = accept;
    strb.shift  = busy && mdc && (divCnt == '0);
    strb.sample = riseNow;
    strb.finish = lastFall;
    strb.bitIdx = riseCnt;
  end

  // R3: MDC stays low outside a frame
  p_mdc_idle_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
  // R2: busy only rises in response to a command strobe
  p_busy_from_cmd_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdWr));
  // R3: never more than a frame's worth of rising edges
  p_rise_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (riseCnt <= IDXW'(FRAME_LEN)));
endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mdioStrobe_t strb,
  input  logic [1:0]  cmdOp,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic        mdioOe,
  output logic [15:0] rdData
);
  logic [FRAME_LEN-1:0] frameSr;
  logic [15:0]          rdSr;
  logic                 isRead;
  logic [17:0]          tail;

  assign tail    = (cmdOp == OP_RD) ? 18'h3FFFF : {2'b10, wrData};
  assign mdioOut = frameSr[FRAME_LEN-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSr <= '1;
      rdSr    <= '0;
      rdData  <= '0;
      isRead  <= 1'b0;
      mdioOe  <= 1'b0;
    end else begin
      if (strb.load) begin
        frameSr <= {32'hFFFF_FFFF, 2'b01, cmdOp, phyAddr, regAddr, tail};
        isRead  <= (cmdOp == OP_RD);
        mdioOe  <= 1'b1;
      end else if (strb.shift) begin
        frameSr <= {frameSr[FRAME_LEN-2:0], 1'b1};
        if (isRead && (strb.bitIdx == IDXW'(TA_POS))) mdioOe <= 1'b0;
      end
      if (strb.sample && (strb.bitIdx >= IDXW'(DATA_POS)))
        rdSr <= {rdSr[14:0], mdioIn};
      if (strb.finish) begin
        mdioOe <= 1'b0;
        if (isRead) rdData <= rdSr;
      end
    end
  end

  // R6: master is released from turnaround on in a read frame
  p_read_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sample && isRead && (strb.bitIdx >= IDXW'(TA_POS))) |-> !mdioOe);
  // R5: master drives every bit of a write frame
  p_write_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sample && !isRead) |-> mdioOe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdWr,
  input  logic [1:0]      cmdOp,
  input  logic [4:0]      phyAddr,
  input  logic [4:0]      regAddr,
  input  logic [15:0]     wrData,
  input  logic [DIVW-1:0] divSel,
  input  logic            doneClr,
  output logic [15:0]     rdData,
  output logic            busy,
  output logic            doneFlag,
  output logic            mdc,
  output logic            mdioOut,
  output logic            mdioOe,
  input  logic            mdioIn
);
  mdioStrobe_t strb;

  mdio_ctrl #(.DIVW(DIVW)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdOp(cmdOp), .divSel(divSel),
    .busy(busy), .mdc(mdc), .strb(strb)
  );

  mdio_dpath uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdOp(cmdOp), .phyAddr(phyAddr),
    .regAddr(regAddr), .wrData(wrData), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .rdData(rdData)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            doneFlag <= 1'b0;
    else if (strb.finish) doneFlag <= 1'b1;
    else if (doneClr)     doneFlag <= 1'b0;
  end

  // R7: completion flag accompanies the end of busy
  p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneFlag);
  // R6: read result only moves when a frame ends
  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> $fell(busy));
  // R5: no drive on MDIO while idle
  p_oe_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int DIVW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWr = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic [4:0] phyAddr = '0, regAddr = '0;
  logic [15:0] wrData = '0;
  logic [DIVW-1:0] divSel = 8'd1;
  logic doneClr = 1'b0;
  logic [15:0] rdData;
  logic busy, doneFlag, mdc, mdioOut, mdioOe;
  logic mdioIn = 1'b1;

  int nChk = 0, nFail = 0;
  int riseCnt = 0;
  logic [63:0] capBits, capOe;
  logic [15:0] phyData = '0;

  always #2.5 clk = ~clk;

  mdio_master #(.DIVW(DIVW)) dut (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdOp(cmdOp), .phyAddr(phyAddr),
    .regAddr(regAddr), .wrData(wrData), .divSel(divSel), .doneClr(doneClr),
    .rdData(rdData), .busy(busy), .doneFlag(doneFlag), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // model PHY: records each bit at MDC rise, presents next read bit
  initial forever begin
    @(posedge mdc);
    if (riseCnt < 64) begin
      capBits[63-riseCnt] = mdioOut;
      capOe[63-riseCnt]   = mdioOe;
    end
    riseCnt++;
    if (riseCnt >= 48 && riseCnt <= 63) mdioIn = phyData[63-riseCnt];
    else mdioIn = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] expFrame(input logic [1:0] op, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, op, pa, ra, 2'b10, wd};
  endfunction

  function automatic logic [63:0] expOe(input logic [1:0] op);
    return (op == 2'b01) ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'h0};
  endfunction

  task automatic runTxn(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd, input int ds, input logic [15:0] pd,
                        input bit disturb, input bit clrAtEnd);
    int cnt;
    logic [15:0] prevRd;
    logic [63:0] ef;
    prevRd  = rdData;
    phyData = pd;
    riseCnt = 0;
    @(negedge clk);
    cmdWr = 1'b1; cmdOp = op; phyAddr = pa; regAddr = ra; wrData = wd; divSel = DIVW'(ds);
    @(negedge clk);
    cmdWr = 1'b0;
    chk(busy === 1'b1, "R2", "busy after accept", 64'(busy), 64'd1);
    cnt = 0;
    while (busy === 1'b1 && cnt < 100000) begin
      cnt++;
      if (disturb && cnt == 20) begin
        cmdWr = 1'b1; cmdOp = 2'b10; phyAddr = ~pa; regAddr = ~ra; wrData = ~wd;
        divSel = DIVW'(ds + 1);
      end else cmdWr = 1'b0;
      if (clrAtEnd && cnt == 128 * ds) doneClr = 1'b1;
      @(negedge clk);
    end
    doneClr = 1'b0;
    cmdWr = 1'b0;
    chk(cnt == 128 * ds, disturb ? "R9" : "R2", "busy duration", 64'(cnt), 64'(128 * ds));
    chk(riseCnt == 64, "R3", "MDC rising edges", 64'(riseCnt), 64'd64);
    chk(mdc === 1'b0, "R3", "mdc low after frame", 64'(mdc), 64'd0);
    ef = expFrame(op, pa, ra, wd);
    if (op == 2'b01) begin
      chk(capBits === ef, disturb ? "R8" : "R5", "write frame", capBits, ef);
      chk(rdData === prevRd, "R6", "rdData kept on write", 64'(rdData), 64'(prevRd));
    end else begin
      chk(capBits[63:18] === ef[63:18], disturb ? "R8" : "R4", "read header",
          64'(capBits[63:18]), 64'(ef[63:18]));
      chk(rdData === pd, "R6", "read data", 64'(rdData), 64'(pd));
    end
    chk(capOe === expOe(op), op == 2'b01 ? "R5" : "R6", "oe pattern", capOe, expOe(op));
    chk(doneFlag === 1'b1, "R7", clrAtEnd ? "set wins over clear" : "flag set",
        64'(doneFlag), 64'd1);
    repeat (3) @(negedge clk);
    chk(doneFlag === 1'b1, "R7", "flag sticky", 64'(doneFlag), 64'd1);
    doneClr = 1'b1;
    @(negedge clk);
    doneClr = 1'b0;
    chk(doneFlag === 1'b0, "R7", "flag cleared", 64'(doneFlag), 64'd0);
  endtask

  task automatic tryIgnored(input logic [1:0] op, input int ds, input string what);
    riseCnt = 0;
    @(negedge clk);
    cmdWr = 1'b1; cmdOp = op; divSel = DIVW'(ds);
    @(negedge clk);
    cmdWr = 1'b0;
    chk(busy === 1'b0, "R8", {what, " busy"}, 64'(busy), 64'd0);
    repeat (10) @(negedge clk);
    chk(riseCnt == 0 && mdc === 1'b0 && busy === 1'b0, "R8", {what, " no MDC activity"},
        64'(riseCnt), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    logic [1:0] op;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk({busy, doneFlag, mdc, mdioOe} === 4'b0, "R1", "control outputs",
        64'({busy, doneFlag, mdc, mdioOe}), 64'd0);
    chk(rdData === 16'h0, "R1", "rdData", 64'(rdData), 64'd0);

    // directed corners
    runTxn(2'b01, 5'd31, 5'd31, 16'hFFFF, 5, 16'h0, 1'b0, 1'b0);
    runTxn(2'b10, 5'd0, 5'd0, 16'h0, 1, 16'h8001, 1'b0, 1'b0);
    runTxn(2'b01, 5'd0, 5'd0, 16'h0000, 1, 16'h0, 1'b0, 1'b0);
    runTxn(2'b10, 5'd17, 5'd2, 16'h0, 3, 16'hA5C3, 1'b1, 1'b0);
    runTxn(2'b01, 5'd9, 5'd14, 16'h1234, 2, 16'h0, 1'b1, 1'b1);
    tryIgnored(2'b00, 2, "op 00");
    tryIgnored(2'b11, 2, "op 11");
    tryIgnored(2'b10, 0, "divSel 0");

    // random mix
    for (int i = 0; i < 24; i++) begin
      op = ($urandom % 2) ? 2'b10 : 2'b01;
      runTxn(op, 5'($urandom), 5'($urandom), 16'($urandom), 1 + int'($urandom % 4),
             16'($urandom), 1'b0, (i % 5) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule